// File: doc/BRIEF.md
# Dual-Port Banked Memory Conflict Arbiter

This block fronts an on-chip word memory that is built from several independent single-ported banks. Each clock cycle a processor pipeline may offer two accesses, one on port A and one on port B. Each access is a load or a store with a byte address. When the two accesses land in different banks, both are carried out in that cycle. When they land in the same bank, the block serves port A at once, raises a stall towards the pipeline for that cycle, and serves port B in the next cycle from a copy it took of B's request.

Loads return their data one cycle after the access reaches the bank. After a collision, the two load results are held back and handed over together in the cycle after B's access. The pipeline can then collect both results at the point where it resumes. A per-bank enable and write-enable vector shows which banks are driven in each cycle.

Top module: `banked_mem_arbiter`

## Requirements
- R1: The 16-bit word at byte address `addr` sits in bank `addr[2:1]` at row `addr[9:3]`. Bit 0 selects nothing, so two addresses that differ only in bit 0 reach the same word. `bank_en[k]` is high in exactly the cycles in which bank k performs an access.
- R2: When both ports are valid and their bank fields differ, `a_gnt` and `b_gnt` are both high in that cycle, `stall` is low, and exactly two bits of `bank_en` are set.
- R3: When both ports are valid and their bank fields are equal, the cycle has `stall`=1, `a_gnt`=1, `b_gnt`=0, and only A's bank is enabled. In the next cycle `stall`=0, `a_gnt`=0, `b_gnt`=1, and B's access (as latched in the collision cycle) is the only bank access.
- R4: `stall` is never high in two consecutive cycles. All port inputs presented in the cycle after a collision are ignored: they perform no access and change no memory word.
- R5: A load granted without a collision returns `*_rvld`=1 with its data in the next cycle. After a collision, each load of the pair returns its data two cycles after the collision cycle, and A's and B's results appear in that same cycle.
- R6: Within a collision, A's access takes effect before B's. A load on B from the address that A stores returns A's new data.
- R7: A load on one port and a store on the other, in different banks, both complete in the same cycle without a stall.
- R8: A port whose valid input is low never causes a stall, is never granted, and never writes memory, even with its write flag high and its bank equal to the other port's.
- R9: While `rst` is high and in the cycle after it falls, with no requests, all grants, `stall`, `bank_en`, `bank_we` and both `*_rvld` outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_vld | input | 1 | Port A request valid |
| a_we | input | 1 | Port A store (1) or load (0) |
| a_addr | input | 10 | Port A byte address |
| a_wdata | input | 16 | Port A store data |
| b_vld | input | 1 | Port B request valid |
| b_we | input | 1 | Port B store (1) or load (0) |
| b_addr | input | 10 | Port B byte address |
| b_wdata | input | 16 | Port B store data |
| a_gnt | output | 1 | Port A access performed this cycle |
| b_gnt | output | 1 | Port B access performed this cycle |
| stall | output | 1 | Same-bank collision; pipeline must hold one cycle |
| bank_en | output | 4 | Per-bank access enable |
| bank_we | output | 4 | Per-bank write enable |
| a_rvld | output | 1 | Port A load data valid |
| a_rdata | output | 16 | Port A load data |
| b_rvld | output | 1 | Port B load data valid |
| b_rdata | output | 16 | Port B load data |

## Verification
Pairs of loads that always hit different banks show that the dual grant happens with no stall and with single-cycle latency. Same-bank load pairs, including back-to-back collisions, show the A-then-B order, the one-cycle stall and the joint return two cycles later. Mixed pairs, a store and a load to one address in one bank, separate whether B sees A's store. Changed inputs during the second cycle of a collision, and an invalid port whose write flag is high, show that nothing outside a granted access reaches memory. Pairs that differ only in address bit 0 separate correct bank and row decoding from an off-by-one slice.

// File: rtl/banked_arb_pkg.sv
package banked_arb_pkg;
  typedef enum logic {
    ST_OPEN   = 1'b0,
    ST_SECOND = 1'b1
  } arb_state_e;
endpackage

// File: rtl/bank_ram.sv
module bank_ram #(
  parameter int DW = 16,
  parameter int RW = 7
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [RW-1:0] row,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << RW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[row] <= wdata;
      rdata <= mem[row];
    end
  end
endmodule

// File: rtl/bank_conflict_ctrl.sv
module bank_conflict_ctrl
  import banked_arb_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 16,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_vld,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  input  logic          b_vld,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic          a_gnt,
  output logic          b_gnt,
  output logic          stall,
  output logic          sa_v,
  output logic          sa_we,
  output logic [AW-1:0] sa_addr,
  output logic [DW-1:0] sa_wdata,
  output logic          sb_v,
  output logic          sb_we,
  output logic [AW-1:0] sb_addr,
  output logic [DW-1:0] sb_wdata
);
  localparam int OFS = $clog2(DW / 8);
  localparam int BB  = $clog2(NB);

  arb_state_e    state_q;
  logic          collide;
  logic          lb_we;
  logic [AW-1:0] lb_addr;
  logic [DW-1:0] lb_wdata;

  assign collide = a_vld && b_vld && (a_addr[OFS +: BB] == b_addr[OFS +: BB]);

  always_comb begin
    sa_we    = a_we;
    sa_addr  = a_addr;
    sa_wdata = a_wdata;
    if (state_q == ST_SECOND) begin
      a_gnt    = 1'b0;
      b_gnt    = 1'b1;
      stall    = 1'b0;
      sa_v     = 1'b0;
      sb_v     = 1'b1;
      sb_we    = lb_we;
      sb_addr  = lb_addr;
      sb_wdata = lb_wdata;
    end else begin
      a_gnt    = a_vld;
      b_gnt    = b_vld && !collide;
      stall    = collide;
      sa_v     = a_vld;
      sb_v     = b_vld && !collide;
      sb_we    = b_we;
      sb_addr  = b_addr;
      sb_wdata = b_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_OPEN;
      lb_we    <= 1'b0;
      lb_addr  <= '0;
      lb_wdata <= '0;
    end else begin
      if (state_q == ST_OPEN && collide) begin
        state_q  <= ST_SECOND;
        lb_we    <= b_we;
        lb_addr  <= b_addr;
        lb_wdata <= b_wdata;
      end else begin
        state_q  <= ST_OPEN;
      end
    end
  end

  // R3: port A goes first in a collision cycle
  a_r3_a_first: assert property (@(posedge clk) disable iff (rst)
    stall |-> (a_gnt && !b_gnt));

  // R3: port B is served in the cycle after the collision
  a_r3_b_second: assert property (@(posedge clk) disable iff (rst)
    stall |=> (b_gnt && !a_gnt));

  // R4: the stall never lasts longer than one cycle
  a_r4_stall_single: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall);

  // R8: without two valid requests there is no stall
  a_r8_invalid_no_stall: assert property (@(posedge clk) disable iff (rst)
    !(a_vld && b_vld) |-> !stall);
endmodule

// File: rtl/banked_mem_arbiter.sv
module banked_mem_arbiter #(
  parameter int AW = 10,
  parameter int DW = 16,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_vld,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  input  logic          b_vld,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic          a_gnt,
  output logic          b_gnt,
  output logic          stall,
  output logic [NB-1:0] bank_en,
  output logic [NB-1:0] bank_we,
  output logic          a_rvld,
  output logic [DW-1:0] a_rdata,
  output logic          b_rvld,
  output logic [DW-1:0] b_rdata
);
  localparam int OFS = $clog2(DW / 8);
  localparam int BB  = $clog2(NB);
  localparam int RW  = AW - OFS - BB;

  logic          sa_v, sa_we, sb_v, sb_we;
  logic [AW-1:0] sa_addr, sb_addr;
  logic [DW-1:0] sa_wdata, sb_wdata;
  logic [DW-1:0] bank_q [NB];

  logic          ra_v, ra_defer, rb_v, hold_v;
  logic [BB-1:0] ra_bank, rb_bank;
  logic [DW-1:0] hold_d;
  logic          unused_ofs;

  assign unused_ofs = ^{sa_addr[OFS-1:0], sb_addr[OFS-1:0]};

  bank_conflict_ctrl #(.AW(AW), .DW(DW), .NB(NB)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .a_vld   (a_vld),
    .a_we    (a_we),
    .a_addr  (a_addr),
    .a_wdata (a_wdata),
    .b_vld   (b_vld),
    .b_we    (b_we),
    .b_addr  (b_addr),
    .b_wdata (b_wdata),
    .a_gnt   (a_gnt),
    .b_gnt   (b_gnt),
    .stall   (stall),
    .sa_v    (sa_v),
    .sa_we   (sa_we),
    .sa_addr (sa_addr),
    .sa_wdata(sa_wdata),
    .sb_v    (sb_v),
    .sb_we   (sb_we),
    .sb_addr (sb_addr),
    .sb_wdata(sb_wdata)
  );

  for (genvar k = 0; k < NB; k++) begin : g_bank
    logic          hit_a, hit_b;
    logic [RW-1:0] row_k;
    logic [DW-1:0] wd_k;

    assign hit_a      = sa_v && (sa_addr[OFS +: BB] == BB'(k));
    assign hit_b      = sb_v && (sb_addr[OFS +: BB] == BB'(k));
    assign bank_en[k] = hit_a || hit_b;
    assign bank_we[k] = hit_a ? sa_we : (hit_b && sb_we);
    assign row_k      = hit_a ? sa_addr[AW-1 -: RW] : sb_addr[AW-1 -: RW];
    assign wd_k       = hit_a ? sa_wdata : sb_wdata;

    bank_ram #(.DW(DW), .RW(RW)) u_ram (
      .clk  (clk),
      .en   (bank_en[k]),
      .we   (bank_we[k]),
      .row  (row_k),
      .wdata(wd_k),
      .rdata(bank_q[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ra_v     <= 1'b0;
      ra_defer <= 1'b0;
      ra_bank  <= '0;
      rb_v     <= 1'b0;
      rb_bank  <= '0;
      hold_v   <= 1'b0;
      hold_d   <= '0;
    end else begin
      ra_v     <= sa_v && !sa_we;
      ra_defer <= stall;
      ra_bank  <= sa_addr[OFS +: BB];
      rb_v     <= sb_v && !sb_we;
      rb_bank  <= sb_addr[OFS +: BB];
      hold_v   <= ra_v && ra_defer;
      if (ra_v && ra_defer) hold_d <= bank_q[ra_bank];
    end
  end

  assign a_rvld  = (ra_v && !ra_defer) || hold_v;
  assign a_rdata = hold_v ? hold_d : bank_q[ra_bank];
  assign b_rvld  = rb_v;
  assign b_rdata = bank_q[rb_bank];

  // R2: a dual grant drives two distinct banks
  a_r2_dual_two_banks: assert property (@(posedge clk) disable iff (rst)
    (a_gnt && b_gnt) |-> ($countones(bank_en) == 2));

  // R3: during a collision only one bank is driven
  a_r3_one_bank: assert property (@(posedge clk) disable iff (rst)
    stall |-> ($countones(bank_en) == 1));

  // R5: uncontested load returns after one cycle
  a_r5_read_latency: assert property (@(posedge clk) disable iff (rst)
    (a_gnt && !a_we && !stall) |=> a_rvld);

  // R5: a collided load on A is held back one cycle
  a_r5_no_early_a: assert property (@(posedge clk) disable iff (rst)
    (stall && !a_we) |=> !a_rvld);

  // R5: a collided load pair returns together
  a_r5_joint_return: assert property (@(posedge clk) disable iff (rst)
    (stall && !a_we && !b_we) |=> ##1 (a_rvld && b_rvld));
endmodule

// File: tb/tb_banked_mem_arbiter.sv
module tb_banked_mem_arbiter;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int NB = 4;
  localparam int WORDS = 1 << (AW - 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          a_vld = 0, a_we = 0, b_vld = 0, b_we = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic          a_gnt, b_gnt, stall, a_rvld, b_rvld;
  logic [NB-1:0] bank_en, bank_we;
  logic [DW-1:0] a_rdata, b_rdata;

  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] model [WORDS];
  int qa_d[$], qa_c[$], qb_d[$], qb_c[$];

  banked_mem_arbiter #(.AW(AW), .DW(DW), .NB(NB)) dut (.*);

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int w);
    return DW'(w * 40503) ^ 16'h5a5a;
  endfunction

  function automatic logic [AW-1:0] ba(input int w);
    return AW'(w << 1);
  endfunction

  task automatic op(input logic av, input logic awe, input logic [AW-1:0] aad, input logic [DW-1:0] awd,
                    input logic bv, input logic bwe, input logic [AW-1:0] bad, input logic [DW-1:0] bwd,
                    input bit junk, input string req);
    bit confl;
    int n, exp_en;
    @(negedge clk);
    a_vld = av; a_we = awe; a_addr = aad; a_wdata = awd;
    b_vld = bv; b_we = bwe; b_addr = bad; b_wdata = bwd;
    #1;
    n = cyc;
    confl = av && bv && (aad[2:1] == bad[2:1]);
    check(stall == confl, {req, " R3 stall"}, stall, confl);
    check(a_gnt == av, {req, " R8 a_gnt"}, a_gnt, av);
    check(b_gnt == (bv && !confl), {req, " R2 b_gnt"}, b_gnt, bv && !confl);
    exp_en = 0;
    if (av) exp_en |= 1 << aad[2:1];
    if (bv && !confl) exp_en |= 1 << bad[2:1];
    check(bank_en == NB'(exp_en), {req, " R1 bank_en"}, bank_en, exp_en);
    if (av) begin
      if (awe) model[aad[AW-1:1]] = awd;
      else begin qa_d.push_back(model[aad[AW-1:1]]); qa_c.push_back(confl ? n + 2 : n + 1); end
    end
    if (bv) begin
      if (bwe) model[bad[AW-1:1]] = bwd;
      else begin qb_d.push_back(model[bad[AW-1:1]]); qb_c.push_back(confl ? n + 2 : n + 1); end
    end
    if (confl) begin
      @(negedge clk);
      if (junk) begin
        a_vld = 1; a_we = 1; a_addr = ba(100); a_wdata = 16'hdead;
        b_vld = 1; b_we = 1; b_addr = ba(201); b_wdata = 16'hbeef;
      end
      #1;
      check(stall == 0, {req, " R4 stall second cycle"}, stall, 0);
      check(a_gnt == 0 && b_gnt == 1, {req, " R3 B served second"}, {a_gnt, b_gnt}, 1);
      check(bank_en == NB'(1 << bad[2:1]), {req, " R3 B bank only"}, bank_en, 1 << bad[2:1]);
    end
  endtask

  always @(negedge clk) begin
    int d, c;
    if (!rst) begin
      if (a_rvld) begin
        if (qa_d.size() == 0) check(0, "R5 port A unexpected data", a_rdata, 0);
        else begin
          d = qa_d.pop_front(); c = qa_c.pop_front();
          check(a_rdata == DW'(d), "R6 port A load data", a_rdata, d);
          check(cyc == c, "R5 port A return cycle", cyc, c);
        end
      end
      if (b_rvld) begin
        if (qb_d.size() == 0) check(0, "R5 port B unexpected data", b_rdata, 0);
        else begin
          d = qb_d.pop_front(); c = qb_c.pop_front();
          check(b_rdata == DW'(d), "R6 port B load data", b_rdata, d);
          check(cyc == c, "R5 port B return cycle", cyc, c);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({a_gnt, b_gnt, stall, a_rvld, b_rvld} == 0 && bank_en == 0 && bank_we == 0,
          "R9 outputs in reset", {a_gnt, b_gnt, stall, a_rvld, b_rvld}, 0);
    rst = 0;
    @(negedge clk);
    check({a_gnt, b_gnt, stall, a_rvld, b_rvld} == 0 && bank_en == 0,
          "R9 outputs after reset", {a_gnt, b_gnt, stall, a_rvld, b_rvld}, 0);

    // R7 fill: stores on both ports into neighbouring banks
    for (int w = 0; w < WORDS; w += 2)
      op(1, 1, ba(w), pat(w), 1, 1, ba(w + 1), pat(w + 1), 0, "R7 fill");

    // R2 load pairs across distinct banks
    for (int i = 0; i < 16; i++)
      op(1, 0, ba(i * 4 + (i % 4)), 0, 1, 0, ba(i * 4 + 64 + ((i + 2) % 4)), 0, 0, "R2 dual load");

    // R7 load and store in different banks, both directions
    op(1, 0, ba(8), 0, 1, 1, ba(13), 16'h1313, 0, "R7 load+store");
    op(1, 1, ba(22), 16'h2222, 1, 0, ba(13), 0, 0, "R7 store+load");
    op(1, 0, ba(22), 0, 0, 0, ba(0), 0, 0, "R7 readback");

    // R3 same-bank load pairs, back to back
    for (int i = 0; i < 6; i++)
      op(1, 0, ba(i * 4 + 1), 0, 1, 0, ba(i * 4 + 41), 0, 0, "R3 collide load");

    // R6 collision: A stores, B loads the same word
    op(1, 1, ba(30), 16'hc0de, 1, 0, ba(30), 0, 0, "R6 store then load");
    // R6 collision: A loads, B stores in same bank
    op(1, 0, ba(34), 0, 1, 1, ba(38), 16'h7777, 0, "R6 load then store");
    op(1, 0, ba(38), 0, 1, 0, ba(35), 0, 0, "R6 readback");

    // R1 byte offset bit 0 ignored
    op(1, 1, ba(45) | 10'd1, 16'h4545, 0, 0, ba(0), 0, 0, "R1 odd byte store");
    op(0, 0, ba(0), 0, 1, 0, ba(45), 0, 0, "R1 even byte load");

    // R4 inputs during second cycle of a collision are ignored
    op(1, 0, ba(3), 0, 1, 0, ba(7), 0, 1, "R4 junk during hold");
    op(1, 0, ba(100), 0, 1, 0, ba(201), 0, 0, "R4 junk addresses unchanged");

    // R8 invalid port with write flag high in same bank
    op(0, 1, ba(52), 16'hbad0, 1, 0, ba(56), 0, 0, "R8 invalid A");
    op(1, 0, ba(60), 0, 0, 1, ba(64), 16'hbad1, 0, "R8 invalid B");
    op(1, 0, ba(52), 0, 1, 0, ba(65), 0, 0, "R8 readback A");
    op(1, 0, ba(64), 0, 0, 0, ba(0), 0, 0, "R8 readback B");

    @(negedge clk);
    a_vld = 0; b_vld = 0;
    repeat (4) @(negedge clk);
    check(qa_d.size() == 0, "R5 port A results outstanding", qa_d.size(), 0);
    check(qb_d.size() == 0, "R5 port B results outstanding", qb_d.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule